// File: doc/BRIEF.md
# Pointer-Addressed Byte RAM Window

This block gives a host that only sees a small byte-wide register space access to a larger internal byte RAM. The RAM has no addresses of its own in that space. The host loads a RAM pointer through two byte registers, one for the upper pointer bits and one for the lower eight. It then moves data through two command registers. A register write to the store command puts the byte into RAM at the pointer. A register read of the fetch command returns the RAM byte at the pointer.

Every access through a command register moves the pointer forward by one. A whole block can therefore be streamed through a single register address. The pointer wraps from the last RAM location back to zero. The RAM is a single-port array with a registered read. To let a fetch return its byte in the same cycle as the register read, the block keeps the byte at the current pointer fetched ahead of time. It refetches that byte whenever the pointer moves.

Top module: `ram_window`

## Requirements
- R1: After synchronous active-low reset the pointer is zero, so reading the upper-pointer register (0x1A) and the lower-pointer register (0x1B) both return 0x00.
- R2: With the default depth of 512 bytes, only bit 0 of a byte written to 0x1A is kept as pointer bit 8. A read of 0x1A returns that bit in position 0, and bits 7..1 always read as zero.
- R3: A byte written to 0x1B becomes pointer bits 7..0 and reads back unchanged from 0x1B.
- R4: A register write to 0x1C stores the written byte at the current pointer and then advances the pointer by one.
- R5: A register read of 0x1D returns, in that same cycle, the RAM byte at the current pointer, and then advances the pointer by one.
- R6: Advancing from pointer DEPTH-1 (0x1FF by default) gives pointer zero, for both store and fetch commands.
- R7: Writing either pointer register discards the byte fetched ahead, so the next 0x1D read returns the byte at the newly loaded pointer.
- R8: Reads of 0x1D on consecutive clock cycles return successive RAM bytes with no idle cycle between them.
- R9: Reads of any address other than 0x1A, 0x1B and 0x1D return 0x00. Reads of 0x1C, and register writes to any address other than 0x1A, 0x1B and 0x1C, leave the pointer and RAM unchanged.
- R10: A 0x1D read that comes at least one cycle after the most recent 0x1C store returns correct data. This holds even when the store wrote the location just before the one being read.
- R11: If the write and read strobes are both high in one cycle, only the write is performed, the read data is 0x00, and the pointer advances at most once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid in the cycle of reg_rd_en |

## Verification
The assertions check the following on every cycle:
- the pointer value right after reset;
- the single-step advance with wrap on each store or fetch command;
- that the pointer holds still on every other kind of cycle;
- that the unused upper bits of the pointer read as zero;
- that unmapped reads and collision cycles return zero;
- that a fetch is never issued while the byte fetched ahead is still being refilled.

Whether the returned bytes are the right ones can only be shown by the bench's scenarios. That covers data written earlier and read back after pointer reloads, back-to-back streaming, wraparound at the top of the RAM, and a fetch just after a store.

// File: rtl/ram_window_pkg.sv
package ram_window_pkg;

    // Register offsets the host decodes.
    localparam logic [7:0] REG_PTR_HI = 8'h1A;
    localparam logic [7:0] REG_PTR_LO = 8'h1B;
    localparam logic [7:0] REG_STORE  = 8'h1C;
    localparam logic [7:0] REG_FETCH  = 8'h1D;

    // Kind of register access decoded in one cycle.
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_LD_HI,
        ACC_LD_LO,
        ACC_STORE,
        ACC_FETCH,
        ACC_OTHER
    } access_e;

endpackage

// File: rtl/ram_window_ptr.sv
// RAM pointer register for the byte RAM window.
// Holds an AW-bit pointer loaded a byte at a time, advances with wrap at
// DEPTH-1, and presents the next-cycle value so the RAM can fetch ahead.
// Assumes load and advance requests are never asserted together.
module ram_window_ptr #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH),
    localparam int HW = (AW > 8) ? AW - 8 : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_hi,
    input  logic          ld_lo,
    input  logic          adv,
    input  logic [7:0]    wdata,
    output logic [AW-1:0] ptr_q,
    output logic [AW-1:0] ptr_d,
    output logic [7:0]    hi_byte,
    output logic [7:0]    lo_byte
);

    logic [AW-1:0] ptr_inc;

    // Increment with wrap from the last location to zero.
    always_comb ptr_inc = (ptr_q == AW'(DEPTH - 1)) ? '0 : ptr_q + AW'(1);

    generate
        if (AW > 8) begin : g_wide
            // Next pointer: byte loads replace their field, advance steps.
            always_comb begin
                ptr_d = ptr_q;
                if (ld_hi)      ptr_d[AW-1:8] = wdata[HW-1:0];
                else if (ld_lo) ptr_d[7:0]    = wdata;
                else if (adv)   ptr_d         = ptr_inc;
            end
            // Byte views of the pointer, unused upper bits read zero.
            always_comb begin
                hi_byte = '0;
                hi_byte[HW-1:0] = ptr_q[AW-1:8];
                lo_byte = ptr_q[7:0];
            end
        end else begin : g_narrow
            // Next pointer when the whole pointer fits in the low byte.
            always_comb begin
                ptr_d = ptr_q;
                if (ld_lo)    ptr_d = wdata[AW-1:0];
                else if (adv) ptr_d = ptr_inc;
            end
            // Byte views; the upper byte is always zero here.
            always_comb begin
                hi_byte = '0;
                lo_byte = '0;
                lo_byte[AW-1:0] = ptr_q;
            end
        end
    endgenerate

    // Pointer state with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

endmodule

// File: rtl/ram_window_spram.sv
// Single-port byte RAM model with registered read.
// Each cycle either writes at addr or reads addr into rdata_q; a write
// cycle leaves rdata_q unchanged. No reset on contents or read data.
module ram_window_spram #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata_q
);

    logic [7:0] mem [DEPTH];

    // Single port: write or registered read, never both.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        else    rdata_q   <= mem[addr];
    end

endmodule

// File: rtl/ram_window_prefetch.sv
// Validity tracker for the byte fetched ahead of the pointer.
// The RAM output holds the byte at the current pointer on every cycle that
// follows a read cycle of the port; a store cycle spends the port, so the
// following cycle's data is marked stale until the refill completes.
module ram_window_prefetch (
    input  logic clk,
    input  logic rst_n,
    input  logic port_write,
    output logic pf_valid
);

    // Track whether the last port cycle was a fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) pf_valid <= 1'b0;
        else        pf_valid <= !port_write;
    end

endmodule

// File: rtl/ram_window.sv
// Register-mapped window onto an internal byte RAM.
// Decodes the four window registers, drives the pointer, steers the single
// RAM port between stores and fetch-ahead reads, and returns read data in
// the cycle of the register read. Assumes reg_addr/reg_wdata are stable in
// the cycle their strobe is high.
module ram_window
    import ram_window_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_en,
    input  logic       reg_rd_en,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata
);

    access_e       acc;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] ptr_d;
    logic [7:0]    hi_byte;
    logic [7:0]    lo_byte;
    logic [7:0]    ram_q;
    logic          pf_valid;
    logic          port_write;
    logic [AW-1:0] port_addr;

    // Decode the access; a write strobe wins over a read strobe.
    always_comb begin
        acc = ACC_NONE;
        if (reg_wr_en) begin
            unique case (reg_addr)
                REG_PTR_HI: acc = ACC_LD_HI;
                REG_PTR_LO: acc = ACC_LD_LO;
                REG_STORE:  acc = ACC_STORE;
                default:    acc = ACC_OTHER;
            endcase
        end else if (reg_rd_en) begin
            acc = (reg_addr == REG_FETCH) ? ACC_FETCH : ACC_OTHER;
        end
    end

    ram_window_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_hi   (acc == ACC_LD_HI),
        .ld_lo   (acc == ACC_LD_LO),
        .adv     (acc == ACC_STORE || acc == ACC_FETCH),
        .wdata   (reg_wdata),
        .ptr_q   (ptr_q),
        .ptr_d   (ptr_d),
        .hi_byte (hi_byte),
        .lo_byte (lo_byte)
    );

    // Port steering: store at the pointer, else fetch the next pointer.
    always_comb begin
        port_write = (acc == ACC_STORE);
        port_addr  = port_write ? ptr_q : ptr_d;
    end

    ram_window_spram #(.DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .we      (port_write),
        .addr    (port_addr),
        .wdata   (reg_wdata),
        .rdata_q (ram_q)
    );

    ram_window_prefetch u_pf (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_write (port_write),
        .pf_valid   (pf_valid)
    );

    // Read-data mux; zero outside a pure read of a readable register.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd_en && !reg_wr_en) begin
            unique case (reg_addr)
                REG_PTR_HI: reg_rdata = hi_byte;
                REG_PTR_LO: reg_rdata = lo_byte;
                REG_FETCH:  reg_rdata = ram_q;
                default:    reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ram_window_chk.sv
// Cycle-by-cycle property checker for ram_window, attached by bind.
// Observes the register port plus the pointer and fetch-ahead valid flag.
module ram_window_chk
    import ram_window_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH),
    localparam int HW = (AW > 8) ? AW - 8 : 0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr_en,
    input logic          reg_rd_en,
    input logic [7:0]    reg_addr,
    input logic [7:0]    reg_rdata,
    input logic [AW-1:0] ptr,
    input logic          pf_valid
);

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    logic is_store, is_fetch, is_load;
    always_comb begin
        is_store = reg_wr_en && reg_addr == REG_STORE;
        is_fetch = reg_rd_en && !reg_wr_en && reg_addr == REG_FETCH;
        is_load  = reg_wr_en && (reg_addr == REG_PTR_HI || reg_addr == REG_PTR_LO);
    end

    // R1: pointer is zero in the first cycle out of reset.
    a_r1_reset_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> ptr == '0);

    // R4, R6: store advances the pointer by one with wrap.
    a_r4_store_adv: assert property (@(posedge clk) disable iff (!rst_n)
        is_store |=> ptr == step($past(ptr)));

    // R5, R6: fetch advances the pointer by one with wrap.
    a_r5_fetch_adv: assert property (@(posedge clk) disable iff (!rst_n)
        is_fetch |=> ptr == step($past(ptr)));

    // R9: other accesses leave the pointer alone.
    a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_store || is_fetch || is_load) |=> $stable(ptr));

    // R2: bits above the pointer width read as zero from the upper register.
    a_r2_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && !reg_wr_en && reg_addr == REG_PTR_HI)
            |-> (reg_rdata >> HW) == 8'h00);

    // R9: unmapped reads return zero.
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && !reg_wr_en && reg_addr != REG_PTR_HI &&
         reg_addr != REG_PTR_LO && reg_addr != REG_FETCH) |-> reg_rdata == 8'h00);

    // R11: collision cycles return zero read data.
    a_r11_collide_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_wr_en) |-> reg_rdata == 8'h00);

    // R10: a fetch is only issued when the byte fetched ahead is ready.
    a_r10_fetch_ready: assert property (@(posedge clk) disable iff (!rst_n)
        is_fetch |-> pf_valid);

endmodule

bind ram_window ram_window_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .ptr       (ptr_q),
    .pf_valid  (pf_valid)
);

// File: tb/tb_ram_window.sv
module tb_ram_window;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic       reg_rd_en = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;

    int checks = 0;
    int failures = 0;
    logic [7:0] model [DEPTH];

    ram_window #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic set_ptr(input int p);
        reg_write(8'h1A, 8'(p >> 8));
        reg_write(8'h1B, 8'(p));
    endtask

    task automatic check_ptr(input string req, input int p);
        logic [7:0] d;
        reg_read(8'h1A, d); check(req, d, 8'(p >> 8));
        reg_read(8'h1B, d); check(req, d, 8'(p));
    endtask

    task automatic t_reset;
        check_ptr("R1", 0);
    endtask

    task automatic t_pointer_regs;
        logic [7:0] d;
        reg_write(8'h1B, 8'h5A);
        reg_write(8'h1A, 8'hFF);
        reg_read(8'h1A, d); check("R2", d, 8'h01);
        reg_read(8'h1B, d); check("R3", d, 8'h5A);
    endtask

    task automatic t_store_fetch;
        logic [7:0] d;
        set_ptr(16'h010);
        for (int i = 0; i < 4; i++) begin
            reg_write(8'h1C, 8'(8'hA0 + i)); model[16'h010 + i] = 8'(8'hA0 + i);
        end
        check_ptr("R4", 16'h014);
        set_ptr(16'h010);
        for (int i = 0; i < 4; i++) begin
            reg_read(8'h1D, d); check("R5", d, model[16'h010 + i]);
        end
        check_ptr("R5", 16'h014);
    endtask

    task automatic t_burst;
        logic [7:0] d;
        set_ptr(16'h100);
        for (int i = 0; i < 8; i++) begin
            reg_write(8'h1C, 8'(8'h3 * i + 8'h11)); model[16'h100 + i] = 8'(8'h3 * i + 8'h11);
        end
        set_ptr(16'h100);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = 8'h1D;
        for (int i = 0; i < 8; i++) begin
            #1 check("R8", reg_rdata, model[16'h100 + i]);
            @(negedge clk);
        end
        reg_rd_en = 1'b0;
        check_ptr("R8", 16'h108);
    endtask

    task automatic t_wrap;
        logic [7:0] d;
        set_ptr(DEPTH - 1);
        reg_write(8'h1C, 8'hE1); model[DEPTH-1] = 8'hE1;
        check_ptr("R6", 0);
        reg_write(8'h1C, 8'hE2); model[0] = 8'hE2;
        set_ptr(DEPTH - 1);
        reg_read(8'h1D, d); check("R6", d, 8'hE1);
        reg_read(8'h1D, d); check("R6", d, 8'hE2);
        check_ptr("R6", 1);
    endtask

    task automatic t_refetch;
        logic [7:0] d;
        set_ptr(16'h010);
        set_ptr(16'h103);
        reg_read(8'h1D, d); check("R7", d, model[16'h103]);
        reg_write(8'h1B, 8'h12);
        reg_read(8'h1D, d); check("R7", d, model[16'h112 & 16'h1FF]);
    endtask

    task automatic t_after_store;
        logic [7:0] d;
        set_ptr(16'h051); reg_write(8'h1C, 8'h3C); model[16'h051] = 8'h3C;
        set_ptr(16'h050); reg_write(8'h1C, 8'h99); model[16'h050] = 8'h99;
        reg_read(8'h1D, d); check("R10", d, 8'h3C);
    endtask

    task automatic t_unmapped;
        logic [7:0] d;
        set_ptr(16'h020);
        reg_write(8'h1C, 8'h44); model[16'h020] = 8'h44;
        set_ptr(16'h020);
        reg_write(8'h05, 8'h77);
        reg_write(8'h1D, 8'h77);
        reg_read(8'h1C, d); check("R9", d, 8'h00);
        reg_read(8'h05, d); check("R9", d, 8'h00);
        check_ptr("R9", 16'h020);
        reg_read(8'h1D, d); check("R9", d, 8'h44);
    endtask

    task automatic t_collide;
        logic [7:0] d;
        set_ptr(16'h030);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_rd_en = 1'b1; reg_addr = 8'h1C; reg_wdata = 8'hC3;
        #1 check("R11", reg_rdata, 8'h00);
        @(negedge clk);
        reg_wr_en = 1'b0; reg_rd_en = 1'b0;
        model[16'h030] = 8'hC3;
        check_ptr("R11", 16'h031);
        set_ptr(16'h030);
        reg_read(8'h1D, d); check("R11", d, 8'hC3);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pointer_regs();
        t_store_fetch();
        t_burst();
        t_wrap();
        t_refetch();
        t_after_store();
        t_unmapped();
        t_collide();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule